// File: doc/BRIEF.md
# Bundle/Offset Program Counter Sequencer

This block holds the fetch position for a packed instruction format. Fixed-size bundles carry a variable number of instructions. Each instruction is a fixed-size head, packed from the front of the bundle, and a variable-size tail, packed from the back. The program counter names a bundle in its upper field and an instruction slot in its lower field. Alongside it the block keeps a tail pointer. The tail pointer is the number of 5-bit tail units that lie between the back of the bundle and the tail of the current instruction.

The front end issues instructions and reports how many it took in a cycle. The sequencer then moves the offset and the tail pointer forward. After the last instruction of a bundle it moves to the next bundle. A branch names a target bundle and offset. The sequencer rejects a target offset that lies past the last instruction of that bundle. For a target in the middle of a bundle, it rebuilds the tail pointer by summing the tail lengths of the earlier heads, one head per cycle.

The sequencer reads bundle information through a lookup port. It drives a bundle number out, and the same cycle it receives two things back: the offset of that bundle's last instruction, and the tail length of every head. The lookup is combinational.

Top module: `hat_pc_seq`

## Requirements
- R1: After reset, the bundle number, offset and tail pointer are all 0, and busy and the error flag are low.
- R2: An advance request with a nonzero count c, made while idle and with no branch request, moves the offset from o to o+c when o+c is at most the bundle's last-instruction offset. The tail pointer then grows by the tail lengths of heads o through o+c-1. Head i's length is field `info_lens[i*LEN_W +: LEN_W]`, counted in 5-bit units.
- R3: When o+c is greater than the last-instruction offset (`info_cnt`), an advance moves instead to bundle+1 (modulo 2^BUN_W), with offset 0 and tail pointer 0.
- R4: A branch whose target offset is greater than the target bundle's `info_cnt` leaves the PC and tail pointer unchanged. It raises `pc_err` for exactly one cycle.
- R5: A valid branch with target offset 0 loads the PC and a tail pointer of 0 at the accepting edge, and never raises busy.
- R6: A valid branch with target offset k>0 holds busy high for exactly k cycles. It then loads the PC, and the tail pointer equals the sum of the tail lengths of heads 0 through k-1 of the target bundle.
- R7: While busy is high, advance and branch requests are ignored, and the PC stays unchanged until the scan ends.
- R8: When a branch and an advance are requested in the same idle cycle, the branch is taken and the advance is dropped.
- R9: The lookup port shows the requested branch bundle while a branch request is presented idle, the target bundle while busy, and otherwise the current PC bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_req | input | 1 | Sequential advance request |
| adv_cnt | input | CNT_W | Number of instructions issued |
| br_req | input | 1 | Branch request |
| br_bundle | input | BUN_W | Branch target bundle |
| br_ofs | input | OFS_W | Branch target instruction offset |
| look_bundle | output | BUN_W | Bundle number on the lookup port |
| info_cnt | input | OFS_W | Offset of the looked-up bundle's last instruction |
| info_lens | input | NH*LEN_W | Tail length of every head, in 5-bit units |
| pc_bundle | output | BUN_W | PC bundle number |
| pc_ofs | output | OFS_W | PC instruction offset |
| tail_ptr | output | TP_W | Tail pointer in 5-bit units from the bundle end |
| busy | output | 1 | Mid-bundle tail scan in progress |
| pc_err | output | 1 | One-cycle branch target error pulse |

## Verification
The bench builds the block with 3 offset bits (eight heads per bundle), 3-bit tail lengths, 4-bit bundle numbers and an issue width of 2. The sixteen bundles are few enough to sweep every target bundle against every target offset. That sweep covers last-instruction offsets from 0 to 7, so both valid and rejected targets occur. A long run of one- and two-instruction advances steps through the bundles and wraps the bundle number from 15 to 0. It reaches cases where a two-wide issue lands past the end of a bundle.

// File: rtl/hat_seq_pkg.sv
package hat_seq_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_ADV_IN,
    ACT_ADV_NEXT,
    ACT_BR_ERR,
    ACT_BR_ZERO,
    ACT_BR_SCAN,
    ACT_SCAN_DONE
  } seq_act_e;
endpackage

// File: rtl/hat_len_sum.sv
module hat_len_sum #(
  parameter int OFS_W   = 3,
  parameter int LEN_W   = 3,
  parameter int ISS_MAX = 2,
  parameter int CNT_W   = 2,
  parameter int TP_W    = 6
) (
  input  logic [OFS_W-1:0]              base,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [(1<<OFS_W)*LEN_W-1:0]   lens,
  output logic [TP_W-1:0]               sum
);
  logic [TP_W-1:0] term [ISS_MAX];

  // One adder term per issue slot of the advance window.
  for (genvar g = 0; g < ISS_MAX; g++) begin : g_slot
    logic [OFS_W-1:0] idx;
    assign idx     = base + OFS_W'(g);
    assign term[g] = (CNT_W'(g) < cnt) ? TP_W'(lens[int'(idx)*LEN_W +: LEN_W]) : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < ISS_MAX; i++) sum = sum + term[i];
  end
endmodule

// File: rtl/hat_tail_scan.sv
module hat_tail_scan #(
  parameter int OFS_W = 3,
  parameter int LEN_W = 3,
  parameter int TP_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [OFS_W-1:0]              goal_ofs,
  input  logic [(1<<OFS_W)*LEN_W-1:0]   lens,
  output logic                          busy,
  output logic                          done,
  output logic [TP_W-1:0]               sum
);
  logic             busy_q, busy_n;
  logic [OFS_W-1:0] idx_q, idx_n;
  logic [OFS_W-1:0] last_q, last_n;
  logic [TP_W-1:0]  acc_q, acc_n;
  logic             en;

  assign busy = busy_q;
  assign done = busy_q && (idx_q == last_q);
  assign sum  = acc_q + TP_W'(lens[int'(idx_q)*LEN_W +: LEN_W]);
  assign en   = start | busy_q;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    last_n = last_q;
    acc_n  = acc_q;
    if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
      last_n = goal_ofs - OFS_W'(1);
      acc_n  = '0;
    end else if (busy_q) begin
      if (done) begin
        busy_n = 1'b0;
      end else begin
        idx_n = idx_q + OFS_W'(1);
        acc_n = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
    end else if (en) begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      last_q <= last_n;
      acc_q  <= acc_n;
    end
  end
endmodule

// File: rtl/hat_pc_seq.sv
module hat_pc_seq
  import hat_seq_pkg::*;
#(
  parameter int BUN_W   = 8,
  parameter int OFS_W   = 3,
  parameter int LEN_W   = 3,
  parameter int ISS_MAX = 2,
  parameter int CNT_W   = $clog2(ISS_MAX + 1),
  parameter int NH      = 1 << OFS_W,
  parameter int TP_W    = OFS_W + LEN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_req,
  input  logic [CNT_W-1:0]      adv_cnt,
  input  logic                  br_req,
  input  logic [BUN_W-1:0]      br_bundle,
  input  logic [OFS_W-1:0]      br_ofs,
  output logic [BUN_W-1:0]      look_bundle,
  input  logic [OFS_W-1:0]      info_cnt,
  input  logic [NH*LEN_W-1:0]   info_lens,
  output logic [BUN_W-1:0]      pc_bundle,
  output logic [OFS_W-1:0]      pc_ofs,
  output logic [TP_W-1:0]       tail_ptr,
  output logic                  busy,
  output logic                  pc_err
);
  localparam int RW = OFS_W + CNT_W + 1;

  logic [BUN_W-1:0] bun_q, bun_n, tgt_bun_q;
  logic [OFS_W-1:0] ofs_q, ofs_n, tgt_ofs_q;
  logic [TP_W-1:0]  tp_q, tp_n;
  logic             err_q;
  logic             pc_en, tgt_en;
  logic [TP_W-1:0]  win_sum, scan_sum;
  logic             scan_busy, scan_done, scan_start;
  logic [RW-1:0]    reach;
  logic             past_end;
  seq_act_e         act;

  hat_len_sum #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .ISS_MAX(ISS_MAX), .CNT_W(CNT_W), .TP_W(TP_W)
  ) i_win (
    .base(ofs_q), .cnt(adv_cnt), .lens(info_lens), .sum(win_sum)
  );

  hat_tail_scan #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .TP_W(TP_W)
  ) i_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_start), .goal_ofs(br_ofs),
    .lens(info_lens), .busy(scan_busy), .done(scan_done), .sum(scan_sum)
  );

  // Lookup steering: scan target, then pending branch, then current bundle.
  assign look_bundle = scan_busy ? tgt_bun_q : (br_req ? br_bundle : bun_q);

  assign reach    = RW'(ofs_q) + RW'(adv_cnt);
  assign past_end = reach > RW'(info_cnt);

  always_comb begin
    act = ACT_HOLD;
    if (scan_busy) begin
      if (scan_done) act = ACT_SCAN_DONE;
    end else if (br_req) begin
      if (br_ofs > info_cnt)  act = ACT_BR_ERR;
      else if (br_ofs == '0)  act = ACT_BR_ZERO;
      else                    act = ACT_BR_SCAN;
    end else if (adv_req && (adv_cnt != '0)) begin
      act = past_end ? ACT_ADV_NEXT : ACT_ADV_IN;
    end
  end

  assign scan_start = (act == ACT_BR_SCAN);
  assign tgt_en     = scan_start;

  always_comb begin
    pc_en = 1'b1;
    bun_n = bun_q;
    ofs_n = ofs_q;
    tp_n  = tp_q;
    unique case (act)
      ACT_ADV_IN: begin
        ofs_n = ofs_q + OFS_W'(adv_cnt);
        tp_n  = tp_q + win_sum;
      end
      ACT_ADV_NEXT: begin
        bun_n = bun_q + BUN_W'(1);
        ofs_n = '0;
        tp_n  = '0;
      end
      ACT_BR_ZERO: begin
        bun_n = br_bundle;
        ofs_n = '0;
        tp_n  = '0;
      end
      ACT_SCAN_DONE: begin
        bun_n = tgt_bun_q;
        ofs_n = tgt_ofs_q;
        tp_n  = scan_sum;
      end
      default: pc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bun_q <= '0;
      ofs_q <= '0;
      tp_q  <= '0;
    end else if (pc_en) begin
      bun_q <= bun_n;
      ofs_q <= ofs_n;
      tp_q  <= tp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_bun_q <= '0;
      tgt_ofs_q <= '0;
    end else if (tgt_en) begin
      tgt_bun_q <= br_bundle;
      tgt_ofs_q <= br_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (act == ACT_BR_ERR);
  end

  assign pc_bundle = bun_q;
  assign pc_ofs    = ofs_q;
  assign tail_ptr  = tp_q;
  assign busy      = scan_busy;
  assign pc_err    = err_q;
endmodule

// File: rtl/hat_pc_seq_chk.sv
module hat_pc_seq_chk #(
  parameter int BUN_W = 8,
  parameter int OFS_W = 3,
  parameter int CNT_W = 2,
  parameter int TP_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_req,
  input logic [CNT_W-1:0] adv_cnt,
  input logic             br_req,
  input logic [OFS_W-1:0] info_cnt,
  input logic [BUN_W-1:0] pc_bundle,
  input logic [OFS_W-1:0] pc_ofs,
  input logic [TP_W-1:0]  tail_ptr,
  input logic             busy,
  input logic             pc_err
);
  a_r2_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !br_req && adv_req && adv_cnt != '0) |=>
      (pc_ofs != $past(pc_ofs) || pc_bundle != $past(pc_bundle)));

  a_r3_zero_ofs_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ofs == '0) |-> (tail_ptr == '0));

  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pc_err |-> (pc_bundle == $past(pc_bundle) && pc_ofs == $past(pc_ofs)
                && tail_ptr == $past(tail_ptr)));

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(pc_bundle) && $stable(pc_ofs) && !pc_err));

  a_r2_on_head: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !br_req) |-> (pc_ofs <= info_cnt));
endmodule

bind hat_pc_seq hat_pc_seq_chk #(
  .BUN_W(BUN_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .TP_W(TP_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .adv_cnt(adv_cnt),
  .br_req(br_req), .info_cnt(info_cnt), .pc_bundle(pc_bundle),
  .pc_ofs(pc_ofs), .tail_ptr(tail_ptr), .busy(busy), .pc_err(pc_err)
);

// File: tb/test_hat_pc_seq.sv
module test_hat_pc_seq;
  localparam int BUN_W = 4, OFS_W = 3, LEN_W = 3, ISS_MAX = 2;
  localparam int CNT_W = 2, NH = 8, TP_W = 6, NB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adv_req = 1'b0, br_req = 1'b0;
  logic [CNT_W-1:0] adv_cnt = '0;
  logic [BUN_W-1:0] br_bundle = '0, look_bundle, pc_bundle;
  logic [OFS_W-1:0] br_ofs = '0, info_cnt, pc_ofs;
  logic [NH*LEN_W-1:0] info_lens;
  logic [TP_W-1:0] tail_ptr;
  logic busy, pc_err;
  int errors = 0, checks = 0;
  int mb = 0, mo = 0, mt = 0;

  always #10 clk = ~clk;

  hat_pc_seq #(.BUN_W(BUN_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .ISS_MAX(ISS_MAX)) i_hat_pc_seq (
    .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .adv_cnt(adv_cnt),
    .br_req(br_req), .br_bundle(br_bundle), .br_ofs(br_ofs),
    .look_bundle(look_bundle), .info_cnt(info_cnt), .info_lens(info_lens),
    .pc_bundle(pc_bundle), .pc_ofs(pc_ofs), .tail_ptr(tail_ptr),
    .busy(busy), .pc_err(pc_err));

  function automatic int cntf(int b);
    return (b * 5 + 2) % 8;
  endfunction
  function automatic int lenf(int b, int i);
    return ((b * 3 + i * 5) % 6) + 1;
  endfunction
  function automatic int tailf(int b, int o);
    int s = 0;
    for (int i = 0; i < o; i++) s += lenf(b, i);
    return s;
  endfunction

  always_comb begin
    info_cnt = OFS_W'(cntf(int'(look_bundle)));
    for (int i = 0; i < NH; i++)
      info_lens[i*LEN_W +: LEN_W] = LEN_W'(lenf(int'(look_bundle), i));
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pc(string req);
    chk(int'(pc_bundle) == mb, {req, " bundle"}, int'(pc_bundle), mb);
    chk(int'(pc_ofs) == mo, {req, " offset"}, int'(pc_ofs), mo);
    chk(int'(tail_ptr) == mt, {req, " tail"}, int'(tail_ptr), mt);
  endtask

  task automatic advance(int c);
    @(negedge clk);
    adv_req = 1'b1; adv_cnt = CNT_W'(c);
    @(negedge clk);
    adv_req = 1'b0;
    if (mo + c > cntf(mb)) begin
      mb = (mb + 1) % NB; mo = 0; mt = 0;
      chk_pc("R3 wrap");
    end else begin
      for (int i = 0; i < c; i++) mt += lenf(mb, mo + i);
      mo += c;
      chk_pc("R2 advance");
    end
  endtask

  task automatic branch(int b, int o, bit with_adv);
    bit bad;
    int cyc;
    bad = o > cntf(b);
    @(negedge clk);
    br_req = 1'b1; br_bundle = BUN_W'(b); br_ofs = OFS_W'(o);
    adv_req = with_adv; adv_cnt = CNT_W'(1);
    #1 chk(int'(look_bundle) == b, "R9 lookup on request", int'(look_bundle), b);
    @(negedge clk);
    br_req = 1'b0; adv_req = 1'b0;
    chk(pc_err == bad, "R4 error pulse", int'(pc_err), int'(bad));
    cyc = 0;
    while (busy && cyc < 20) begin
      if (cyc == 0)
        chk(int'(look_bundle) == b, "R9 lookup during scan", int'(look_bundle), b);
      // R7: requests during the scan must be ignored
      br_req = 1'b1; br_bundle = BUN_W'((b + 3) % NB); br_ofs = '0;
      adv_req = 1'b1;
      cyc++;
      @(negedge clk);
      br_req = 1'b0; adv_req = 1'b0;
    end
    if (bad) begin
      chk(cyc == 0, "R4 no scan", cyc, 0);
      chk_pc("R4 pc unchanged");
      @(negedge clk);
      chk(pc_err == 1'b0, "R4 one-cycle pulse", int'(pc_err), 0);
    end else begin
      chk(cyc == o, o == 0 ? "R5 no busy" : "R6 busy cycles", cyc, o);
      mb = b; mo = o; mt = tailf(b, o);
      chk_pc(with_adv ? "R8 branch wins" : (o == 0 ? "R5 target" : "R6 R7 target"));
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pc_bundle == '0 && pc_ofs == '0, "R1 reset pc", int'(pc_ofs), 0);
    chk(tail_ptr == '0 && !busy && !pc_err, "R1 reset flags", int'(tail_ptr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pc("R1 idle");
    for (int s = 0; s < 160; s++) advance((s % 3 == 2) ? 2 : 1);
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < NH; o++) begin
        branch(b, o, 1'b0);
        if (o <= cntf(b)) advance(1);
      end
    branch(1, 0, 1'b1);
    branch(4, 3, 1'b1);
    branch(9, 5, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule